// File: doc/BRIEF.md
# Domain-Tagged Address Translation Cache

This block keeps recently used I/O page translations close to the DMA path so that most requests avoid a page-table walk. Each cached entry maps a 36-bit I/O virtual page number to a 40-bit physical page number and carries read and write permission bits. The entry is keyed by a 16-bit domain identifier together with the page number. Two devices in different domains can therefore use the same I/O address and never see each other's mapping. Any of the 16 entries can hold any translation.

A requester presents a domain and a page on the lookup port. A hit returns the physical page and permissions on the next cycle. A miss sends one request to an external walker and then waits for its result. The result is returned to the requester and, unless it is a fault, written into an entry. Only one miss is handled at a time, and the lookup port is not ready while it is open.

Software removes stale mappings through the invalidation port. The modes are: every entry, every entry of one domain, or one page of one domain. Each command takes one cycle and is acknowledged with a done pulse. A command that arrives while a walk is open makes the walk's result uncacheable.

The controller has three states. ST_IDLE accepts lookups. ST_REQ drives the walker request for one cycle. ST_WAIT waits for the walker result. The transitions are:
- ST_IDLE to ST_REQ on an accepted lookup that misses.
- ST_REQ to ST_WAIT always.
- ST_WAIT to ST_IDLE when the walker result arrives.
- A hit keeps the controller in ST_IDLE.

Top module: `dom_xlate_cache`

## Requirements
- R1: A lookup accepted on a clock edge that hits gives rsp_valid=1 and rsp_hit=1, with the stored physical page and permissions, in the cycle after that edge. A hit raises no walker request.
- R2: An entry matches only when both its domain and its page equal the lookup's. The same page number looked up under another domain misses.
- R3: A miss raises wk_req_valid for exactly one cycle, the cycle after acceptance, carrying the looked-up domain and page. lk_ready is low from that cycle until the walker result is taken.
- R4: A walker result (wk_rsp_valid) is taken only in ST_WAIT. In the next cycle it gives rsp_valid=1 and rsp_hit=0 with the walker's page and permissions. A non-fault result is cached, so the same lookup then hits.
- R5: A walker result with wk_rsp_fault=1 is reported with rsp_fault=1, with page and permissions all zero. It is not cached, so repeating the lookup misses again.
- R6: inv_mode selects the invalidation: 2'b00 clears all entries, 2'b01 clears entries whose domain equals inv_dom, 2'b10 clears the entry equal to both inv_dom and inv_vpn, and 2'b11 changes nothing. Every cycle with inv_valid=1 gives inv_done=1 in the following cycle.
- R7: A lookup accepted in the same cycle as an invalidation sees the entries that invalidation removes as already gone.
- R8: If an invalidation occurs in ST_REQ or ST_WAIT, including in the cycle the walker result arrives, the result is still returned but is not cached.
- R9: A fill takes the lowest-numbered invalid entry. When all entries are valid, it takes the entry at a replacement pointer. The pointer starts at 0 after reset and advances by one, wrapping, on each fill that uses it.
- R10: After reset all entries are invalid, lk_ready=1, and rsp_valid, wk_req_valid and inv_done are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_dom | input | 16 | Lookup domain |
| lk_vpn | input | 36 | Lookup I/O virtual page |
| lk_ready | output | 1 | Lookup can be accepted (ST_IDLE) |
| rsp_valid | output | 1 | Translation result valid |
| rsp_hit | output | 1 | Result came from the cache |
| rsp_fault | output | 1 | Walker reported a fault |
| rsp_ppn | output | 40 | Physical page |
| rsp_rd | output | 1 | Read permitted |
| rsp_wr | output | 1 | Write permitted |
| wk_req_valid | output | 1 | Walk request |
| wk_req_dom | output | 16 | Walk domain |
| wk_req_vpn | output | 36 | Walk page |
| wk_rsp_valid | input | 1 | Walk result valid |
| wk_rsp_fault | input | 1 | Walk found no valid mapping |
| wk_rsp_ppn | input | 40 | Walk physical page |
| wk_rsp_rd | input | 1 | Walk read permission |
| wk_rsp_wr | input | 1 | Walk write permission |
| inv_valid | input | 1 | Invalidation command |
| inv_mode | input | 2 | Invalidation mode |
| inv_dom | input | 16 | Invalidation domain |
| inv_vpn | input | 36 | Invalidation page |
| inv_done | output | 1 | Invalidation acknowledge |

## Verification
- A hit result is due one cycle after the edge that accepts the lookup.
- On a miss, the walker request appears in that same next cycle and is gone one cycle later.
- A walker result driven in ST_WAIT produces the response one cycle after its edge.
- inv_done follows each command by one cycle.
- The bench drives every input at the falling edge and samples at the following falling edge, exactly one rising edge later. Its reference model applies any same-cycle invalidation before predicting a hit or a miss, and treats an invalidation during a walk as cancelling the fill.

// File: rtl/dxc_pkg.sv
package dxc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2
    } fsm_t;

    typedef enum logic [1:0] {
        INV_ALL  = 2'b00,
        INV_DOM  = 2'b01,
        INV_PAGE = 2'b10,
        INV_NONE = 2'b11
    } inv_mode_t;
endpackage

// File: rtl/dxc_match.sv
module dxc_match
    import dxc_pkg::*;
#(
    parameter int N  = 16,
    parameter int DW = 16,
    parameter int VW = 36
) (
    input  logic [N-1:0]  ent_valid,
    input  logic [DW-1:0] ent_dom [N],
    input  logic [VW-1:0] ent_vpn [N],
    input  logic [DW-1:0] q_dom,
    input  logic [VW-1:0] q_vpn,
    input  logic          inv_valid,
    input  logic [1:0]    inv_mode,
    input  logic [DW-1:0] inv_dom,
    input  logic [VW-1:0] inv_vpn,
    output logic [N-1:0]  hit_vec,
    output logic [N-1:0]  kill_vec
);
    inv_mode_t mode;
    assign mode = inv_mode_t'(inv_mode);

    for (genvar i = 0; i < N; i++) begin : g_ent
        logic q_dom_eq, q_vpn_eq, i_dom_eq, i_vpn_eq;
        assign q_dom_eq = (ent_dom[i] == q_dom);
        assign q_vpn_eq = (ent_vpn[i] == q_vpn);
        assign i_dom_eq = (ent_dom[i] == inv_dom);
        assign i_vpn_eq = (ent_vpn[i] == inv_vpn);
        assign kill_vec[i] = inv_valid &&
                             ((mode == INV_ALL) ||
                              (mode == INV_DOM  && i_dom_eq) ||
                              (mode == INV_PAGE && i_dom_eq && i_vpn_eq));
        assign hit_vec[i]  = ent_valid[i] && !kill_vec[i] && q_dom_eq && q_vpn_eq;
    end
endmodule

// File: rtl/dxc_victim.sv
module dxc_victim #(
    parameter int N  = 16,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  ent_valid,
    input  logic [IW-1:0] rr_ptr,
    output logic [IW-1:0] victim,
    output logic          use_rr
);
    always_comb begin
        victim = rr_ptr;
        use_rr = 1'b1;
        for (int i = N - 1; i >= 0; i--) begin
            if (!ent_valid[i]) begin
                victim = IW'(i);
                use_rr = 1'b0;
            end
        end
    end
endmodule

// File: rtl/dom_xlate_cache.sv
module dom_xlate_cache
    import dxc_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int DOM_W   = 16,
    parameter int VPN_W   = 36,
    parameter int PPN_W   = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_valid,
    input  logic [DOM_W-1:0] lk_dom,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             lk_ready,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic             rsp_fault,
    output logic [PPN_W-1:0] rsp_ppn,
    output logic             rsp_rd,
    output logic             rsp_wr,
    output logic             wk_req_valid,
    output logic [DOM_W-1:0] wk_req_dom,
    output logic [VPN_W-1:0] wk_req_vpn,
    input  logic             wk_rsp_valid,
    input  logic             wk_rsp_fault,
    input  logic [PPN_W-1:0] wk_rsp_ppn,
    input  logic             wk_rsp_rd,
    input  logic             wk_rsp_wr,
    input  logic             inv_valid,
    input  logic [1:0]       inv_mode,
    input  logic [DOM_W-1:0] inv_dom,
    input  logic [VPN_W-1:0] inv_vpn,
    output logic             inv_done
);
    localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    // Entry storage
    logic [ENTRIES-1:0] ent_valid;
    logic [DOM_W-1:0]   ent_dom [ENTRIES];
    logic [VPN_W-1:0]   ent_vpn [ENTRIES];
    logic [PPN_W-1:0]   ent_ppn [ENTRIES];
    logic [ENTRIES-1:0] ent_rd, ent_wr;

    fsm_t state, nstate;
    logic [DOM_W-1:0] pend_dom;
    logic [VPN_W-1:0] pend_vpn;
    logic             stale;
    logic [IW-1:0]    rr_ptr, victim;
    logic             use_rr;

    logic [ENTRIES-1:0] hit_vec, kill_vec;
    logic               hit_any, lk_fire, wk_take, fill_en;
    logic [PPN_W-1:0]   hit_ppn;
    logic               hit_rd, hit_wr;

    dxc_match #(.N(ENTRIES), .DW(DOM_W), .VW(VPN_W)) u_match (
        .ent_valid (ent_valid),
        .ent_dom   (ent_dom),
        .ent_vpn   (ent_vpn),
        .q_dom     (lk_dom),
        .q_vpn     (lk_vpn),
        .inv_valid (inv_valid),
        .inv_mode  (inv_mode),
        .inv_dom   (inv_dom),
        .inv_vpn   (inv_vpn),
        .hit_vec   (hit_vec),
        .kill_vec  (kill_vec)
    );

    dxc_victim #(.N(ENTRIES)) u_victim (
        .ent_valid (ent_valid),
        .rr_ptr    (rr_ptr),
        .victim    (victim),
        .use_rr    (use_rr)
    );

    always_comb begin
        hit_ppn = '0;
        hit_rd  = 1'b0;
        hit_wr  = 1'b0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (hit_vec[i]) begin
                hit_ppn = hit_ppn | ent_ppn[i];
                hit_rd  = hit_rd  | ent_rd[i];
                hit_wr  = hit_wr  | ent_wr[i];
            end
        end
    end

    assign hit_any = |hit_vec;
    assign lk_fire = lk_valid && (state == ST_IDLE);
    assign wk_take = (state == ST_WAIT) && wk_rsp_valid;
    assign fill_en = wk_take && !wk_rsp_fault && !stale && !inv_valid;

    // Next-state logic
    always_comb begin
        nstate = state;
        unique case (state)
            ST_IDLE: if (lk_fire && !hit_any) nstate = ST_REQ;
            ST_REQ:  nstate = ST_WAIT;
            ST_WAIT: if (wk_rsp_valid) nstate = ST_IDLE;
            default: nstate = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nstate;
    end

    // Pending miss context and stale marking
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_dom <= '0;
            pend_vpn <= '0;
            stale    <= 1'b0;
        end else if (lk_fire) begin
            pend_dom <= lk_dom;
            pend_vpn <= lk_vpn;
            stale    <= 1'b0;
        end else if (state != ST_IDLE && inv_valid) begin
            stale    <= 1'b1;
        end
    end

    // Entry array: invalidation then fill
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_valid <= '0;
            rr_ptr    <= '0;
        end else begin
            ent_valid <= ent_valid & ~kill_vec;
            if (fill_en) begin
                ent_valid[victim] <= 1'b1;
                ent_dom[victim]   <= pend_dom;
                ent_vpn[victim]   <= pend_vpn;
                ent_ppn[victim]   <= wk_rsp_ppn;
                ent_rd[victim]    <= wk_rsp_rd;
                ent_wr[victim]    <= wk_rsp_wr;
                if (use_rr)
                    rr_ptr <= (rr_ptr == IW'(ENTRIES - 1)) ? '0 : rr_ptr + 1'b1;
            end
        end
    end

    // Outputs
    assign lk_ready     = (state == ST_IDLE);
    assign wk_req_valid = (state == ST_REQ);
    assign wk_req_dom   = pend_dom;
    assign wk_req_vpn   = pend_vpn;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_fault <= 1'b0;
            rsp_ppn   <= '0;
            rsp_rd    <= 1'b0;
            rsp_wr    <= 1'b0;
            inv_done  <= 1'b0;
        end else begin
            inv_done  <= inv_valid;
            rsp_valid <= 1'b0;
            if (lk_fire && hit_any) begin
                rsp_valid <= 1'b1;
                rsp_hit   <= 1'b1;
                rsp_fault <= 1'b0;
                rsp_ppn   <= hit_ppn;
                rsp_rd    <= hit_rd;
                rsp_wr    <= hit_wr;
            end else if (wk_take) begin
                rsp_valid <= 1'b1;
                rsp_hit   <= 1'b0;
                rsp_fault <= wk_rsp_fault;
                rsp_ppn   <= wk_rsp_fault ? '0 : wk_rsp_ppn;
                rsp_rd    <= wk_rsp_rd && !wk_rsp_fault;
                rsp_wr    <= wk_rsp_wr && !wk_rsp_fault;
            end
        end
    end

    // Checks beside the logic they guard
    AST_HIT_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        lk_fire && hit_any |=> rsp_valid && rsp_hit && !wk_req_valid); // R1
    AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec)); // R2
    AST_REQ_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        wk_req_valid |=> !wk_req_valid && !lk_ready); // R3
    AST_WALK_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        wk_take |=> rsp_valid && !rsp_hit); // R4
    AST_FAULT_NOT_CACHED: assert property (@(posedge clk) disable iff (!rst_n)
        wk_take && wk_rsp_fault && !inv_valid |=> $stable(ent_valid)); // R5
    AST_GLOBAL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        inv_valid && inv_mode == 2'b00 |=> ent_valid == '0 && inv_done); // R6
    AST_STALE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        wk_take && stale && !inv_valid |=> $stable(ent_valid)); // R8
endmodule

// File: tb/sim_dom_xlate_cache.sv
`timescale 1ns/1ps
module sim_dom_xlate_cache;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [15:0] lk_dom = '0;
    logic [35:0] lk_vpn = '0;
    logic        lk_ready, rsp_valid, rsp_hit, rsp_fault, rsp_rd, rsp_wr;
    logic [39:0] rsp_ppn;
    logic        wk_req_valid;
    logic [15:0] wk_req_dom;
    logic [35:0] wk_req_vpn;
    logic        wk_rsp_valid = 1'b0, wk_rsp_fault = 1'b0, wk_rsp_rd = 1'b0, wk_rsp_wr = 1'b0;
    logic [39:0] wk_rsp_ppn = '0;
    logic        inv_valid = 1'b0;
    logic [1:0]  inv_mode = '0;
    logic [15:0] inv_dom = '0;
    logic [35:0] inv_vpn = '0;
    logic        inv_done;

    always #2 clk = ~clk;

    dom_xlate_cache u0 (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_dom(lk_dom), .lk_vpn(lk_vpn), .lk_ready(lk_ready),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_fault(rsp_fault),
        .rsp_ppn(rsp_ppn), .rsp_rd(rsp_rd), .rsp_wr(rsp_wr),
        .wk_req_valid(wk_req_valid), .wk_req_dom(wk_req_dom), .wk_req_vpn(wk_req_vpn),
        .wk_rsp_valid(wk_rsp_valid), .wk_rsp_fault(wk_rsp_fault), .wk_rsp_ppn(wk_rsp_ppn),
        .wk_rsp_rd(wk_rsp_rd), .wk_rsp_wr(wk_rsp_wr),
        .inv_valid(inv_valid), .inv_mode(inv_mode), .inv_dom(inv_dom), .inv_vpn(inv_vpn),
        .inv_done(inv_done)
    );

    int n_chk = 0;
    int n_err = 0;
    bit finished = 0;

    // Reference state
    bit          m_v [16];
    logic [15:0] m_d [16];
    logic [35:0] m_p [16];
    int          m_rr = 0;

    function automatic logic [39:0] f_ppn(logic [15:0] d, logic [35:0] v);
        return {d[7:0], 32'h0} ^ {4'h0, v} ^ 40'hA5_0000_1000;
    endfunction
    function automatic bit f_fault(logic [15:0] d, logic [35:0] v);
        return d[0] && (v[2:0] == 3'b111);
    endfunction
    function automatic bit f_rd(logic [15:0] d, logic [35:0] v);
        return !v[0] || d[1];
    endfunction
    function automatic bit f_wr(logic [35:0] v);
        return v[1];
    endfunction

    function automatic int m_find(logic [15:0] d, logic [35:0] v);
        for (int i = 0; i < 16; i++) if (m_v[i] && m_d[i] == d && m_p[i] == v) return i;
        return -1;
    endfunction

    function automatic void m_inv(logic [1:0] md, logic [15:0] d, logic [35:0] v);
        for (int i = 0; i < 16; i++) begin
            if (md == 2'b00) m_v[i] = 0;
            else if (md == 2'b01 && m_d[i] == d) m_v[i] = 0;
            else if (md == 2'b10 && m_d[i] == d && m_p[i] == v) m_v[i] = 0;
        end
    endfunction

    function automatic void m_fill(logic [15:0] d, logic [35:0] v);
        int slot = -1;
        for (int i = 0; i < 16; i++) if (!m_v[i] && slot < 0) slot = i;
        if (slot < 0) begin
            slot = m_rr;
            m_rr = (m_rr + 1) % 16;
        end
        m_v[slot] = 1; m_d[slot] = d; m_p[slot] = v;
    endfunction

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic drive_inv(logic [1:0] md, logic [15:0] d, logic [35:0] v);
        inv_valid = 1; inv_mode = md; inv_dom = d; inv_vpn = v;
    endtask

    // One lookup; optional invalidation in the same cycle (same) or during the walk (mid)
    task automatic lookup(logic [15:0] d, logic [35:0] v, int lat, bit same, bit mid,
                          logic [1:0] im, logic [15:0] id, logic [35:0] iv, string req);
        bit exp_hit;
        if (same) m_inv(im, id, iv);
        exp_hit = (m_find(d, v) >= 0);
        @(negedge clk);
        chk(lk_ready == 1, req, "lk_ready before lookup", lk_ready, 1);
        lk_valid = 1; lk_dom = d; lk_vpn = v;
        if (same) drive_inv(im, id, iv);
        @(negedge clk);
        lk_valid = 0; inv_valid = 0;
        if (same) chk(inv_done == 1, "R6", "inv_done", inv_done, 1);
        chk((rsp_valid && rsp_hit) == exp_hit, req, "hit flag", rsp_valid && rsp_hit, exp_hit);
        if (rsp_valid && rsp_hit) begin
            chk(rsp_ppn == f_ppn(d, v), "R1", "hit ppn", rsp_ppn, f_ppn(d, v));
            chk({rsp_rd, rsp_wr} == {f_rd(d, v), f_wr(v)}, "R1", "hit perms",
                {rsp_rd, rsp_wr}, {f_rd(d, v), f_wr(v)});
            chk(wk_req_valid == 0, "R1", "no walk on hit", wk_req_valid, 0);
        end else begin
            chk(wk_req_valid == 1 && wk_req_dom == d && wk_req_vpn == v, "R3", "walk request",
                {wk_req_valid, wk_req_dom}, {1'b1, d});
            chk(lk_ready == 0, "R3", "lk_ready during walk", lk_ready, 0);
            @(negedge clk);
            chk(wk_req_valid == 0, "R3", "request lasts one cycle", wk_req_valid, 0);
            if (mid) begin
                drive_inv(im, id, iv);
                @(negedge clk);
                inv_valid = 0;
                m_inv(im, id, iv);
                chk(inv_done == 1, "R6", "inv_done mid walk", inv_done, 1);
            end
            repeat (lat) @(negedge clk);
            wk_rsp_valid = 1; wk_rsp_fault = f_fault(d, v); wk_rsp_ppn = f_ppn(d, v);
            wk_rsp_rd = f_rd(d, v); wk_rsp_wr = f_wr(v);
            @(negedge clk);
            wk_rsp_valid = 0;
            chk(rsp_valid == 1 && rsp_hit == 0, "R4", "walk response", {rsp_valid, rsp_hit}, 2'b10);
            if (f_fault(d, v)) begin
                chk(rsp_fault == 1 && rsp_ppn == 0 && !rsp_rd && !rsp_wr, "R5", "fault response",
                    {rsp_fault, rsp_ppn}, {1'b1, 40'h0});
            end else begin
                chk(rsp_fault == 0 && rsp_ppn == f_ppn(d, v), "R4", "walk ppn", rsp_ppn, f_ppn(d, v));
                chk({rsp_rd, rsp_wr} == {f_rd(d, v), f_wr(v)}, "R4", "walk perms",
                    {rsp_rd, rsp_wr}, {f_rd(d, v), f_wr(v)});
            end
            if (!exp_hit && !f_fault(d, v) && !mid) m_fill(d, v);
        end
    endtask

    task automatic inv_cmd(logic [1:0] md, logic [15:0] d, logic [35:0] v);
        @(negedge clk);
        drive_inv(md, d, v);
        @(negedge clk);
        inv_valid = 0;
        m_inv(md, d, v);
        chk(inv_done == 1, "R6", "inv_done", inv_done, 1);
        @(negedge clk);
        chk(inv_done == 0, "R6", "inv_done single pulse", inv_done, 0);
    endtask

    task automatic lk(logic [15:0] d, logic [35:0] v, string req);
        lookup(d, v, 1, 0, 0, 2'b00, 16'h0, 36'h0, req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 16; i++) begin m_v[i] = 0; m_d[i] = '0; m_p[i] = '0; end
        repeat (4) @(negedge clk);
        chk(lk_ready == 1 && rsp_valid == 0 && wk_req_valid == 0 && inv_done == 0, "R10",
            "state in reset", {lk_ready, rsp_valid, wk_req_valid, inv_done}, 4'b1000);
        rst_n = 1;
        @(negedge clk);
        chk(lk_ready == 1 && rsp_valid == 0, "R10", "state after reset", {lk_ready, rsp_valid}, 2'b10);

        // R4 miss then hit, R1
        lk(16'd1, 36'h100, "R10 first lookup misses");
        lk(16'd1, 36'h100, "R1");
        // R2 same page, other domain
        lk(16'd2, 36'h100, "R2");
        lk(16'd2, 36'h100, "R2");
        lk(16'd1, 36'h100, "R2");
        // R5 faults not cached
        lk(16'd1, 36'h7, "R5");
        lk(16'd1, 36'h7, "R5");
        // R6 page, domain and no-op modes
        inv_cmd(2'b10, 16'd1, 36'h100);
        lk(16'd2, 36'h100, "R6 page keeps other domain");
        lk(16'd1, 36'h100, "R6 page removed");
        inv_cmd(2'b01, 16'd2, 36'h0);
        lk(16'd1, 36'h100, "R6 domain keeps other");
        lk(16'd2, 36'h100, "R6 domain removed");
        inv_cmd(2'b11, 16'd1, 36'h100);
        lk(16'd1, 36'h100, "R6 mode 11 no effect");
        // R7 same-cycle invalidation
        lookup(16'd1, 36'h100, 0, 1, 0, 2'b10, 16'd1, 36'h100, "R7");
        lk(16'd1, 36'h100, "R7 refilled");
        // R8 invalidation during walk, including one at an unrelated domain
        lookup(16'd3, 36'h200, 2, 0, 1, 2'b01, 16'd5, 36'h0, "R8");
        lk(16'd3, 36'h200, "R8 result not cached");
        // R6 global
        inv_cmd(2'b00, 16'd0, 36'h0);
        lk(16'd1, 36'h100, "R6 global cleared");
        lk(16'd2, 36'h100, "R6 global cleared");
        // R9 replacement
        inv_cmd(2'b00, 16'd0, 36'h0);
        for (int i = 0; i < 16; i++) lk(16'd4, 36'(i), "R9 fill");
        lk(16'd4, 36'd16, "R9 pointer victim");
        lk(16'd4, 36'd1, "R9 slot1 kept");
        lk(16'd4, 36'd0, "R9 slot0 replaced");
        lk(16'd4, 36'd1, "R9 pointer advanced");
        lk(16'd4, 36'd2, "R9");
        inv_cmd(2'b10, 16'd4, 36'd5);
        lk(16'd4, 36'd30, "R9 invalid first");
        lk(16'd4, 36'd6, "R9 invalid first");
        lk(16'd4, 36'd3, "R9 invalid first");

        // Constrained random mix
        for (int k = 0; k < 400; k++) begin
            logic [15:0] d = 16'(1 + $urandom % 3);
            logic [35:0] v = 36'($urandom % 24);
            int r = $urandom % 100;
            int lat = $urandom % 3;
            logic [1:0] im = 2'($urandom % 4);
            logic [15:0] id = 16'(1 + $urandom % 3);
            logic [35:0] iv = 36'($urandom % 24);
            if (r < 8) inv_cmd(im, id, iv);
            else if (r < 13) lookup(d, v, lat, 1, 0, im, id, iv, "R7 random");
            else if (r < 18) lookup(d, v, lat, 0, 1, im, id, iv, "R8 random");
            else lookup(d, v, lat, 0, 0, 2'b00, 16'h0, 36'h0, "R2 R9 random");
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule